// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit collects the event indications of an I2C controller's bus engine and turns them into host-visible state. Five events arrive as single-cycle pulses and are held in sticky flags: arbitration lost, no-acknowledge, access ready, stop detected and addressed as slave. Two events are live levels driven by the data path: receive ready and transmit ready. A mask register selects which events may raise the single interrupt line.

The host reaches the unit through a 16-bit register port with three addresses: a mask register, a status register and a vector register. Reading the vector register returns the code of the highest-priority pending enabled event and acknowledges that event. An interrupt handler therefore drains pending work by reading the vector register until it returns zero. The status register shows the sticky flags alongside two live bus conditions. Two of its flags can be cleared by writing a one.

Top module: `i2c_evt_unit`

## Requirements
- R1: After reset the mask register and every sticky flag are zero, `irq_o` is low, and reads of the mask, status and vector registers all return 0.
- R2: The mask register at byte offset 0x04 holds 7 writable bits [6:0]. Bit i enables the event whose vector code is i+1. Bits [15:7] read as 0.
- R3: A pulse on a sticky event input sets its flag from the next cycle on. The flag stays set until it is cleared. Status bits (offset 0x08) show the flags at these positions: arbitration lost at bit 0, no-acknowledge at bit 1, access ready at bit 2, stop detected at bit 5.
- R4: Status bit 11 follows `rx_shift_full_i` and status bit 12 follows `bus_busy_i` in the same cycle. Every status bit not named in R3 or R4 reads 0.
- R5: Writing a 1 to status bit 2 or bit 5 clears that flag. Writing to status bits 0 and 1, or writing 0 to any status bit, has no effect.
- R6: A read of the vector register (offset 0x28) returns the lowest code among the pending events whose mask bit is set. The codes are: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed as slave 7.
- R7: A vector read returns 0 when no enabled event is pending. A vector read never clears an event that is pending but masked.
- R8: A vector read that returns the code of a sticky event clears that flag, and only that flag. A following read returns the next code.
- R9: Receive ready (code 4) and transmit ready (code 5) are pending exactly while `rx_rdy_i` and `tx_rdy_i` are high. A vector read that returns 4 or 5 leaves them pending.
- R10: `irq_o` is high exactly when at least one pending event has its mask bit set.
- R11: When a sticky event pulse arrives in the same cycle that a vector read or status write clears the same flag, the flag stays set.
- R12: Writes to the vector register change nothing. Reads of any offset other than 0x04, 0x08 and 0x28 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 6 | Byte offset of the register access |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_rd_i | input | 1 | Read strobe, one cycle per read; a vector read acknowledges on this cycle's edge |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid in the cycle `reg_rd_i` is high, 0 otherwise |
| arb_lost_i | input | 1 | Pulse: arbitration lost |
| no_ack_i | input | 1 | Pulse: no-acknowledge seen |
| acc_rdy_i | input | 1 | Pulse: access ready |
| stop_i | input | 1 | Pulse: stop condition detected |
| as_slave_i | input | 1 | Pulse: addressed as slave |
| rx_rdy_i | input | 1 | Level: received data waiting |
| tx_rdy_i | input | 1 | Level: transmit register empty |
| rx_shift_full_i | input | 1 | Level: receive shifter full |
| bus_busy_i | input | 1 | Level: bus busy |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a mix of sticky and level events under a partial mask. In that state the drain sequence must stop at a level code, masked flags must survive, and the status register must show exactly the flags that were not acknowledged. The bench reaches it with a sweep of all 128 event combinations under several masks. For each combination it first raises the levels and fires the pulses in one cycle, then drains the vector register while an arithmetic model predicts each code, and finally compares the leftover flags through the status register. The race between a new pulse and its own acknowledge is forced by driving the pulse and the vector read in the same cycle.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int unsigned NUM_EVT = 7;
  localparam int unsigned CODE_W  = $clog2(NUM_EVT + 1);
  // index i <-> vector code i+1 <-> mask bit i
  localparam logic [NUM_EVT-1:0] LATCHED_SEL  = 7'b110_0111;
  localparam logic [NUM_EVT-1:0] STAT_SHOW_SEL = 7'b010_0111;
  localparam logic [NUM_EVT-1:0] STAT_W1C_SEL  = 7'b010_0100;
endpackage

// File: rtl/i2c_evt_flag.sv
module i2c_evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // new event beats acknowledge
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_evt_prio.sv
module i2c_evt_prio #(
  parameter int unsigned N  = 7,
  parameter int unsigned CW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = CW'(i + 1);
    end
  end
endmodule

// File: rtl/i2c_evt_mask.sv
module i2c_evt_mask #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/i2c_evt_unit.sv
module i2c_evt_unit
  import i2c_evt_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 6,
  parameter logic [ADDR_W-1:0] MASK_OFS = 6'h04,
  parameter logic [ADDR_W-1:0] STAT_OFS = 6'h08,
  parameter logic [ADDR_W-1:0] VEC_OFS  = 6'h28,
  parameter int unsigned RSFULL_BIT = 11,
  parameter int unsigned BUSY_BIT   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              arb_lost_i,
  input  logic              no_ack_i,
  input  logic              acc_rdy_i,
  input  logic              stop_i,
  input  logic              as_slave_i,
  input  logic              rx_rdy_i,
  input  logic              tx_rdy_i,
  input  logic              rx_shift_full_i,
  input  logic              bus_busy_i,
  output logic              irq_o
);
  logic sel_mask, sel_stat, sel_vec;
  logic mask_we, stat_we, vec_rd;
  logic [NUM_EVT-1:0] evt_in, pend, mask, enabled;
  logic [CODE_W-1:0]  vec_code;
  logic [DATA_W-1:0]  stat_word;
  logic               wdata_unused;

  assign sel_mask = (reg_addr_i == MASK_OFS);
  assign sel_stat = (reg_addr_i == STAT_OFS);
  assign sel_vec  = (reg_addr_i == VEC_OFS);
  assign mask_we  = reg_wr_i & sel_mask;
  assign stat_we  = reg_wr_i & sel_stat;
  assign vec_rd   = reg_rd_i & sel_vec;
  assign wdata_unused = ^reg_wdata_i[DATA_W-1:NUM_EVT];

  assign evt_in = {as_slave_i, stop_i, tx_rdy_i, rx_rdy_i, acc_rdy_i, no_ack_i, arb_lost_i};

  i2c_evt_mask #(.N(NUM_EVT)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we),
    .wdata_i (reg_wdata_i[NUM_EVT-1:0]),
    .mask_o  (mask)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    if (LATCHED_SEL[i]) begin : g_sticky
      logic ack, w1c;
      assign ack = vec_rd & (vec_code == CODE_W'(i + 1));
      assign w1c = STAT_W1C_SEL[i] & stat_we & reg_wdata_i[i];
      i2c_evt_flag u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (evt_in[i]),
        .clr_i  (ack | w1c),
        .flag_o (pend[i])
      );
    end else begin : g_level
      assign pend[i] = evt_in[i];
    end
  end

  assign enabled = pend & mask;
  assign irq_o   = |enabled;

  i2c_evt_prio #(.N(NUM_EVT), .CW(CODE_W)) u_prio (
    .req_i  (enabled),
    .code_o (vec_code)
  );

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (STAT_SHOW_SEL[i]) stat_word[i] = pend[i];
    end
    stat_word[RSFULL_BIT] = rx_shift_full_i;
    stat_word[BUSY_BIT]   = bus_busy_i;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      if (sel_mask)     reg_rdata_o = DATA_W'(mask);
      else if (sel_stat) reg_rdata_o = stat_word;
      else if (sel_vec)  reg_rdata_o = DATA_W'(vec_code);
    end
  end
endmodule

// File: rtl/i2c_evt_unit_chk.sv
module i2c_evt_unit_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STAT_OFS = 6'h08,
  parameter logic [ADDR_W-1:0] VEC_OFS  = 6'h28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              arb_lost_i,
  input logic              acc_rdy_i,
  input logic              irq_o,
  input logic [6:0]        pend_i
);
  logic vec_rd, stat_wr;
  assign vec_rd  = reg_rd_i && (reg_addr_i == VEC_OFS);
  assign stat_wr = reg_wr_i && (reg_addr_i == STAT_OFS);

  AST_PULSE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_i |=> pend_i[0]); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr && reg_wdata_i[2] && !acc_rdy_i |=> !pend_i[2]); // R5
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd |-> reg_rdata_o <= DATA_W'(7)); // R6
  AST_QUIET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd && !irq_o |-> reg_rdata_o == '0); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd && reg_rdata_o == DATA_W'(1) && !arb_lost_i |=> !pend_i[0]); // R8
  AST_IRQ_HAS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd && irq_o |-> reg_rdata_o != '0); // R10
endmodule

bind i2c_evt_unit i2c_evt_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .VEC_OFS(VEC_OFS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .arb_lost_i  (arb_lost_i),
  .acc_rdy_i   (acc_rdy_i),
  .irq_o       (irq_o),
  .pend_i      (pend)
);

// File: tb/tb_i2c_evt_unit.sv
module tb_i2c_evt_unit;
  localparam logic [5:0] A_MASK = 6'h04, A_STAT = 6'h08, A_VEC = 6'h28;
  localparam logic [6:0] LAT = 7'b110_0111;
  localparam logic [6:0] SHOW = 7'b010_0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic wr = 0, rd = 0;
  logic [15:0] wdata = '0, rdata;
  logic al = 0, nack = 0, ardy = 0, stp = 0, aas = 0, rxr = 0, txr = 0, rsf = 0, bb = 0;
  logic irq;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_evt_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .arb_lost_i(al), .no_ack_i(nack),
    .acc_rdy_i(ardy), .stop_i(stp), .as_slave_i(aas), .rx_rdy_i(rxr), .tx_rdy_i(txr),
    .rx_shift_full_i(rsf), .bus_busy_i(bb), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1; addr = a;
    #2 d = rdata;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic fire(input logic [6:0] p);
    @(negedge clk);
    {aas, stp, ardy, nack, al} = {p[6], p[5], p[2], p[1], p[0]};
    @(posedge clk); #1 {aas, stp, ardy, nack, al} = '0;
  endtask

  function automatic logic [15:0] lowest(input logic [6:0] e);
    for (int i = 0; i < 7; i++) if (e[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  task automatic drain_all();
    logic [15:0] d;
    reg_wr(A_MASK, 16'h007F);
    for (int k = 0; k < 9; k++) begin
      reg_rd(A_VEC, d);
      if (d == 0) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [6:0] masks [5] = '{7'h7F, 7'h00, 7'h55, 7'h2A, 7'h1C};
    repeat (3) @(posedge clk);
    #1 chk("R1 irq in reset", 16'(irq), 16'h0);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    reg_rd(A_MASK, d); chk("R1 mask", d, 16'h0);
    reg_rd(A_STAT, d); chk("R1 status", d, 16'h0);
    reg_rd(A_VEC, d);  chk("R1 vector", d, 16'h0);

    // R2 mask width
    reg_wr(A_MASK, 16'hFFFF); reg_rd(A_MASK, d); chk("R2 mask all ones", d, 16'h007F);
    reg_wr(A_MASK, 16'h0012); reg_rd(A_MASK, d); chk("R2 mask pattern", d, 16'h0012);

    // R4 live status bits
    @(negedge clk) begin rsf = 1; bb = 1; end
    reg_rd(A_STAT, d); chk("R4 shift full + busy", d, 16'h1800);
    @(negedge clk) bb = 0;
    reg_rd(A_STAT, d); chk("R4 shift full only", d, 16'h0800);
    @(negedge clk) rsf = 0;

    // R5 write-one-clear
    fire(7'h7F);
    reg_rd(A_STAT, d); chk("R3 all sticky shown", d, 16'h0027);
    reg_wr(A_STAT, 16'h0000); reg_rd(A_STAT, d); chk("R5 zero write no effect", d, 16'h0027);
    reg_wr(A_STAT, 16'hFFFF); reg_rd(A_STAT, d); chk("R5 w1c bits 2,5 only", d, 16'h0003);
    drain_all();
    reg_rd(A_STAT, d); chk("R8 drained status", d, 16'h0);

    // R7 masked event survives vector read
    fire(7'h01); reg_wr(A_MASK, 16'h0000);
    #1 chk("R10 irq masked", 16'(irq), 16'h0);
    reg_rd(A_VEC, d); chk("R7 masked reads zero", d, 16'h0);
    reg_wr(A_MASK, 16'h0001);
    #1 chk("R10 irq enabled", 16'(irq), 16'h1);
    reg_rd(A_VEC, d); chk("R7 masked flag kept", d, 16'h1);
    reg_rd(A_VEC, d); chk("R8 cleared after ack", d, 16'h0);

    // R11 pulse races its own acknowledge
    fire(7'h01);
    @(negedge clk); rd = 1; addr = A_VEC; al = 1;
    #2 d = rdata; chk("R11 race read code", d, 16'h1);
    @(posedge clk); #1 begin rd = 0; al = 0; end
    reg_rd(A_VEC, d); chk("R11 set wins", d, 16'h1);
    reg_rd(A_VEC, d); chk("R11 then cleared", d, 16'h0);
    fire(7'h04);
    @(negedge clk); wr = 1; addr = A_STAT; wdata = 16'h0004; ardy = 1;
    @(posedge clk); #1 begin wr = 0; ardy = 0; end
    reg_rd(A_STAT, d); chk("R11 set beats w1c", d, 16'h0004);
    reg_wr(A_STAT, 16'h0004);

    // R9 level events
    reg_wr(A_MASK, 16'h0018);
    @(negedge clk) rxr = 1;
    reg_rd(A_VEC, d); chk("R9 rx code", d, 16'h4);
    reg_rd(A_VEC, d); chk("R9 rx not cleared", d, 16'h4);
    @(negedge clk) begin rxr = 0; txr = 1; end
    reg_rd(A_VEC, d); chk("R9 tx code", d, 16'h5);
    @(negedge clk) txr = 0;
    reg_rd(A_VEC, d); chk("R9 level gone", d, 16'h0);

    // R12 vector write and unmapped reads
    fire(7'h02); reg_wr(A_MASK, 16'h0002);
    reg_wr(A_VEC, 16'hFFFF);
    reg_rd(A_MASK, d); chk("R12 vec write keeps mask", d, 16'h0002);
    reg_rd(A_STAT, d); chk("R12 vec write keeps flag", d, 16'h0002);
    reg_rd(6'h00, d); chk("R12 unmapped 0x00", d, 16'h0);
    reg_rd(6'h2C, d); chk("R12 unmapped 0x2C", d, 16'h0);
    reg_rd(A_VEC, d); chk("R6 nack code", d, 16'h2);

    // Sweep: all event combinations under several masks
    foreach (masks[mi]) begin
      for (int p = 0; p < 128; p++) begin
        logic [6:0] pv, m, lat, e;
        pv = 7'(p); m = masks[mi]; lat = pv & LAT; e = pv & m;
        @(negedge clk) begin rxr = pv[3]; txr = pv[4]; end
        fire(pv);
        reg_wr(A_MASK, {9'd0, m});
        #1 chk("R10 irq sweep", 16'(irq), 16'(|e));
        reg_rd(A_STAT, d); chk("R3 status sweep", d, 16'(lat & SHOW));
        for (int k = 0; k < 9; k++) begin
          logic [15:0] x;
          x = lowest(e);
          reg_rd(A_VEC, d); chk("R6 R8 drain sweep", d, x);
          if (x == 0 || x == 4 || x == 5) break;
          e[x-1] = 1'b0; lat[x-1] = 1'b0;
        end
        reg_rd(A_STAT, d); chk("R7 leftover status", d, 16'(lat & SHOW));
        @(negedge clk) begin rxr = 0; txr = 0; end
        drain_all();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule